// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Victim Buffer

This block is a first-level data cache. It sits between a load/store processor port and the port to the next memory level. The main array is direct-mapped, and each line holds one data word. Stores always write through to the lower port. A store that misses does not allocate a line.

A small fully associative buffer keeps lines that the main array has evicted. A later read that hits such a line swaps it back into the array, and the line it displaces takes the freed slot. This costs one extra cycle and no memory traffic. When the buffer is full, the oldest pushed line is overwritten first.

A two-bit mode input is sampled only while reset is asserted. It selects pass-through, plain direct-mapped, or direct-mapped with the victim buffer. In pass-through mode every request goes to memory unchanged, and the memory response comes back unchanged.

Top module: `wtcache_top`

## Requirements
- R1: While `rst` is high, `cfgMode` is latched, every line and buffer entry becomes invalid, `cpuDone` and `memReq` are low, and `cpuReady` is high after reset. Changing `cfgMode` after reset has no effect.
- R2: A read that hits the main array raises `cpuDone` in the cycle after acceptance, returns the stored word on `cpuRdata`, and issues no memory request.
- R3: In a cached mode, a read that misses both the array and the buffer issues one memory read at the same word address. It returns the memory word and installs it in the array.
- R4: Every store is forwarded to memory with `memWe` high and the request's address and data. `memReq` stays high with a stable address until `memAck`, and `cpuDone` follows the acknowledge.
- R5: A store that misses does not allocate, so a later read of that address goes to memory.
- R6: A store that hits the main array updates the cached copy, so the next read hits and returns the new word.
- R7: Addresses with equal index bits (`addr[10:0]` at default size) share one line. In plain mode, reading the second address evicts the first, and the first must then be fetched again.
- R8: In victim mode, a line evicted by a read miss is kept in the buffer. A read that hits the buffer swaps the line back: `cpuDone` comes two cycles after acceptance, with no memory request, and the displaced line is now served from the buffer.
- R9: The buffer has 4 entries and is refilled in FIFO order, so the fifth push overwrites the oldest pushed line.
- R10: A store that misses the array but hits the buffer updates the buffer copy, and a later read returns the new word through a swap.
- R11: With `cfgMode`=00 (pass-through), every read and store goes to memory, and `cpuRdata` equals the memory word.
- R12: Mode encoding: 00 pass-through, 01 plain, 10 victim buffer, 11 behaves as plain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode sampled while high |
| cfgMode | input | 2 | Operating mode selection |
| cpuReq | input | 1 | Request, accepted in a cycle with `cpuReady` high |
| cpuWe | input | 1 | 1 = store, 0 = read |
| cpuAddr | input | 16 | Word address |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Block idle and able to accept a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with `cpuDone` |
| memReq | output | 1 | Lower-level request, held until `memAck` |
| memWe | output | 1 | Lower-level write enable |
| memAddr | output | 16 | Lower-level word address |
| memWdata | output | 32 | Lower-level write data |
| memAck | input | 1 | Lower-level completion pulse |
| memRdata | input | 32 | Lower-level read data, valid with `memAck` |

## Verification
The embedded properties check on every cycle the following:
- the one-cycle read hit with no memory traffic;
- forwarding of every store;
- a held and stable memory request;
- the absence of memory traffic during a swap;
- memory forwarding in pass-through mode;
- that no line appears twice in the victim buffer.

Only the directed scenarios can show the data-level behaviours:
- that a store miss leaves no line behind;
- that a conflicting address evicts the old line;
- the FIFO order in which buffer entries are lost;
- that a store into a buffered line survives a later swap;
- that the mode is ignored once reset is released.

// File: rtl/wtcache_pkg.sv
package wtcache_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_PLAIN   = 2'b01,
    MODE_VICTIM  = 2'b10,
    MODE_PLAIN_B = 2'b11
  } cacheMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SWAP = 2'b01,
    ST_MEM  = 2'b10
  } ctrlState_e;

  typedef struct packed {
    logic capture;
    logic rdMain;
    logic storeMain;
    logic storeVictim;
    logic push;
    logic swap;
    logic fill;
    logic latchMem;
  } strobes_t;

endpackage

// File: rtl/wtcache_dp.sv
module wtcache_dp
  import wtcache_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 8192,
  parameter int VB_DEPTH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              mainHit,
  output logic              vbHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int LINES = CACHE_BYTES / (DATA_W / 8);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int VB_PW = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

  logic [DATA_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validArr;

  logic [DATA_W-1:0] vbData [VB_DEPTH];
  logic [ADDR_W-1:0] vbTag  [VB_DEPTH];
  logic [VB_DEPTH-1:0] vbValid;
  logic [VB_DEPTH-1:0] vbMatch;
  logic [VB_PW-1:0]  vbPtr, vbIdx, hitIdxQ;

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWe;
  logic [DATA_W-1:0] reqWdata, rdataQ;

  logic [IDX_W-1:0] cpuIdx, reqIdx;
  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign reqIdx = reqAddr[IDX_W-1:0];

  assign mainHit = validArr[cpuIdx] && (tagArr[cpuIdx] == cpuAddr[ADDR_W-1:IDX_W]);

  for (genvar g = 0; g < VB_DEPTH; g++) begin : g_vbMatch
    assign vbMatch[g] = vbValid[g] && (vbTag[g] == cpuAddr);
  end
  assign vbHit = |vbMatch;

  always_comb begin
    vbIdx = '0;
    for (int i = VB_DEPTH - 1; i >= 0; i--)
      if (vbMatch[i]) vbIdx = VB_PW'(i);
  end

  // request capture and response data
  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr  <= '0;
      reqWe    <= 1'b0;
      reqWdata <= '0;
      hitIdxQ  <= '0;
      rdataQ   <= '0;
    end else begin
      if (stb.capture) begin
        reqAddr  <= cpuAddr;
        reqWe    <= cpuWe;
        reqWdata <= cpuWdata;
        hitIdxQ  <= vbIdx;
      end
      if (stb.rdMain)        rdataQ <= dataArr[cpuIdx];
      else if (stb.swap)     rdataQ <= vbData[hitIdxQ];
      else if (stb.latchMem) rdataQ <= memRdata;
    end
  end

  // main array
  always_ff @(posedge clk) begin
    if (rst) validArr <= '0;
    else if (stb.swap) validArr[reqIdx] <= 1'b1;
    else if (stb.fill) validArr[reqIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.storeMain) begin
      dataArr[cpuIdx] <= cpuWdata;
    end else if (stb.swap) begin
      dataArr[reqIdx] <= vbData[hitIdxQ];
      tagArr[reqIdx]  <= reqAddr[ADDR_W-1:IDX_W];
    end else if (stb.fill) begin
      dataArr[reqIdx] <= memRdata;
      tagArr[reqIdx]  <= reqAddr[ADDR_W-1:IDX_W];
    end
  end

  // victim buffer, FIFO pointer advanced by pushes only
  always_ff @(posedge clk) begin
    if (rst) begin
      vbValid <= '0;
      vbPtr   <= '0;
      for (int i = 0; i < VB_DEPTH; i++) begin
        vbData[i] <= '0;
        vbTag[i]  <= '0;
      end
    end else if (stb.storeVictim) begin
      vbData[vbIdx] <= cpuWdata;
    end else if (stb.push) begin
      if (validArr[cpuIdx]) begin
        vbData[vbPtr]  <= dataArr[cpuIdx];
        vbTag[vbPtr]   <= {tagArr[cpuIdx], cpuIdx};
        vbValid[vbPtr] <= 1'b1;
        vbPtr <= (vbPtr == VB_PW'(VB_DEPTH - 1)) ? '0 : vbPtr + 1'b1;
      end
    end else if (stb.swap) begin
      vbData[hitIdxQ]  <= dataArr[reqIdx];
      vbTag[hitIdxQ]   <= {tagArr[reqIdx], reqIdx};
      vbValid[hitIdxQ] <= validArr[reqIdx];
    end
  end

  assign cpuRdata = rdataQ;
  assign memWe    = reqWe;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;

  // R8
  vb_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vbMatch));

endmodule

// File: rtl/wtcache_ctrl.sv
module wtcache_ctrl
  import wtcache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfgMode,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       mainHit,
  input  logic       vbHit,
  input  logic       memAck,
  output strobes_t   stb,
  output logic       cpuReady,
  output logic       cpuDone,
  output logic       memReq
);
  ctrlState_e state, stateNxt;
  cacheMode_e modeQ;
  logic doneQ, doneNxt;
  logic isPass, isVictim;

  assign isPass   = (modeQ == MODE_PASS);
  assign isVictim = (modeQ == MODE_VICTIM);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    doneNxt  = 1'b0;
    case (state)
      ST_IDLE: if (cpuReq) begin
        stb.capture = 1'b1;
        if (isPass) begin
          stateNxt = ST_MEM;
        end else if (cpuWe) begin
          stb.storeMain   = mainHit;
          stb.storeVictim = isVictim && vbHit && !mainHit;
          stateNxt = ST_MEM;
        end else if (mainHit) begin
          stb.rdMain = 1'b1;
          doneNxt    = 1'b1;
        end else if (isVictim && vbHit) begin
          stateNxt = ST_SWAP;
        end else begin
          stb.push = isVictim;
          stateNxt = ST_MEM;
        end
      end
      ST_SWAP: begin
        stb.swap = 1'b1;
        doneNxt  = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_MEM: if (memAck) begin
        stb.latchMem = 1'b1;
        stb.fill     = !isPass && !cpuWeQ;
        doneNxt      = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  logic cpuWeQ;
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      doneQ  <= 1'b0;
      cpuWeQ <= 1'b0;
      modeQ  <= cacheMode_e'(cfgMode);
    end else begin
      state <= stateNxt;
      doneQ <= doneNxt;
      if (stb.capture) cpuWeQ <= cpuWe;
    end
  end

  assign cpuReady = (state == ST_IDLE);
  assign cpuDone  = doneQ;
  assign memReq   = (state == ST_MEM);

  // R2
  read_hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && cpuReq && !cpuWe && !isPass && mainHit) |=> (cpuDone && !memReq));

  // R8
  swap_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && cpuReq && !cpuWe && isVictim && !mainHit && vbHit) |=> (!memReq && !cpuDone));

  // R11
  pass_to_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && cpuReq && isPass) |=> memReq);

endmodule

// File: rtl/wtcache_top.sv
module wtcache_top
  import wtcache_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 8192,
  parameter int VB_DEPTH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfgMode,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  strobes_t stb;
  logic mainHit, vbHit;

  wtcache_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgMode(cfgMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .mainHit(mainHit), .vbHit(vbHit), .memAck(memAck), .stb(stb),
    .cpuReady(cpuReady), .cpuDone(cpuDone), .memReq(memReq)
  );

  wtcache_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .VB_DEPTH(VB_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .mainHit(mainHit), .vbHit(vbHit),
    .cpuRdata(cpuRdata), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!cpuDone && !memReq && cpuReady));

  // R4
  store_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && cpuReq && cpuWe) |=> (memReq && memWe && memAddr == $past(cpuAddr)));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

endmodule

// File: tb/wtcache_top_tb.sv
module wtcache_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfgMode = 2'b01;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic cpuReady, cpuDone, memReq, memWe;
  logic [31:0] cpuRdata, memWdata;
  logic [15:0] memAddr;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int total = 0, bad = 0, memCount = 0, lat = 0;
  logic [31:0] bmem [512];

  always #5 clk = ~clk;

  wtcache_top u_dut (
    .clk(clk), .rst(rst), .cfgMode(cfgMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuDone(cpuDone),
    .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic int key(input logic [15:0] a);
    return int'({a[15:11], a[3:0]});
  endfunction

  // memory model: acknowledge three cycles after a request appears
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (lat == 2) begin
        memAck   = 1'b1;
        memRdata = bmem[key(memAddr)];
        if (memWe) bmem[key(memAddr)] = memWdata;
        memCount++;
        lat = 0;
      end else lat++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; cfgMode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic doReq(input logic we, input logic [15:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc, output int mu);
    int m0;
    m0 = memCount;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    @(posedge clk); @(negedge clk);
    cpuReq = 1'b0;
    cyc = 1;
    while (!cpuDone && cyc < 200) begin @(negedge clk); cyc++; end
    rd = cpuRdata;
    mu = memCount - m0;
  endtask

  task automatic testResetPlain();
    logic [31:0] rd; int c, mu; logic [31:0] ev;
    doReset(2'b01);
    check(cpuReady && !cpuDone && !memReq, "R1 idle after reset", {cpuReady, cpuDone, memReq}, 32'h4);
    cfgMode = 2'b00; // must be ignored
    ev = bmem[key(16'h0005)];
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(mu == 1 && rd == ev, "R3 read miss fetch", rd, ev);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(c == 1 && mu == 0 && rd == ev, "R2 read hit one cycle", c, 1);
    check(mu == 0, "R1 mode change after reset ignored", mu, 0);
    doReq(1'b1, 16'h0005, 32'h1234_5678, rd, c, mu);
    check(mu == 1 && bmem[key(16'h0005)] == 32'h1234_5678, "R4 store written through", bmem[key(16'h0005)], 32'h1234_5678);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(c == 1 && mu == 0 && rd == 32'h1234_5678, "R6 store hit updates copy", rd, 32'h1234_5678);
    doReq(1'b1, 16'h0007, 32'hBEEF_0007, rd, c, mu);
    doReq(1'b0, 16'h0007, 0, rd, c, mu);
    check(mu == 1 && rd == 32'hBEEF_0007, "R5 store miss no allocate", mu, 1);
    doReq(1'b0, 16'h0805, 0, rd, c, mu);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(mu == 1 && rd == 32'h1234_5678, "R7 conflict evicts", mu, 1);
  endtask

  task automatic testVictim();
    logic [31:0] rd; int c, mu;
    doReset(2'b10);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    doReq(1'b0, 16'h0805, 0, rd, c, mu);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(c == 2 && mu == 0 && rd == bmem[key(16'h0005)], "R8 victim hit swap", c, 2);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(c == 1 && mu == 0, "R8 swapped line now in array", c, 1);
    doReq(1'b0, 16'h0805, 0, rd, c, mu);
    check(c == 2 && mu == 0 && rd == bmem[key(16'h0805)], "R8 displaced line in buffer", c, 2);
    doReq(1'b1, 16'h0005, 32'hCAFE_0005, rd, c, mu);
    check(mu == 1, "R4 store in victim mode forwarded", mu, 1);
    doReq(1'b0, 16'h0005, 0, rd, c, mu);
    check(c == 2 && mu == 0 && rd == 32'hCAFE_0005, "R10 buffer copy updated", rd, 32'hCAFE_0005);
  endtask

  task automatic testFifo();
    logic [31:0] rd; int c, mu;
    doReset(2'b10);
    for (int k = 0; k < 6; k++) doReq(1'b0, 16'(16'h0003 + k * 16'h0800), 0, rd, c, mu);
    doReq(1'b0, 16'h0803, 0, rd, c, mu);
    check(c == 2 && mu == 0, "R9 newer entry kept", c, 2);
    doReq(1'b0, 16'h0003, 0, rd, c, mu);
    check(mu == 1 && rd == bmem[key(16'h0003)], "R9 oldest entry replaced", mu, 1);
  endtask

  task automatic testPass();
    logic [31:0] rd; int c, mu;
    doReset(2'b00);
    cfgMode = 2'b10;
    doReq(1'b0, 16'h0009, 0, rd, c, mu);
    doReq(1'b0, 16'h0009, 0, rd, c, mu);
    check(mu == 1 && rd == bmem[key(16'h0009)], "R11 repeated read forwarded", mu, 1);
    doReq(1'b1, 16'h0009, 32'h0BAD_F00D, rd, c, mu);
    check(mu == 1 && bmem[key(16'h0009)] == 32'h0BAD_F00D, "R11 store forwarded", mu, 1);
    check(mu == 1, "R12 mode 00 is pass-through", mu, 1);
  endtask

  task automatic testAltMode();
    logic [31:0] rd; int c, mu;
    doReset(2'b11);
    doReq(1'b0, 16'h0006, 0, rd, c, mu);
    doReq(1'b0, 16'h0006, 0, rd, c, mu);
    check(c == 1 && mu == 0, "R12 mode 11 caches", c, 1);
    doReq(1'b0, 16'h0806, 0, rd, c, mu);
    doReq(1'b0, 16'h0006, 0, rd, c, mu);
    check(mu == 1, "R12 mode 11 has no victim buffer", mu, 1);
  endtask

  initial begin
    for (int k = 0; k < 512; k++) bmem[k] = 32'hC0DE_0000 ^ (k * 32'h0101);
    testResetPlain();
    testVictim();
    testFifo();
    testPass();
    testAltMode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL all-R watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule